// File: doc/BRIEF.md
# Cascaded Interrupt Controller with Sub-Source Groups

This block collects 32 primary interrupt requests and reduces them to a single request line for the CPU. Most primary positions come straight from peripheral request pins: each pin passes through a synchronizer, and its rising edge records a pending bit. Four primary positions are not fed from pins. Each of them summarises a group of sub-source requests, and every group has its own pending and mask bits. The summary stays asserted while any unmasked sub-source in its group is pending. Two primary positions are reserved and never become pending.

Software works through a small register bus with a combinational read path. It sees five registers: primary pending, primary mask, a one-hot "in service" register, sub-source pending and sub-source mask. Pending bits are cleared by writing ones. When the in-service register is empty, the block loads it with the lowest-numbered primary source that is both pending and unmasked. The CPU request line is high while that register holds a bit.

Top module: `cascade_intc`

## Requirements
- R1: After reset the primary mask reads 0xFFFFFFFF and the sub-source mask reads 0x7FF. Primary pending, in-service and sub-source pending all read zero, and `irq_out` is low. Register offsets are: 0 primary pending, 1 primary mask, 2 in-service, 3 sub-source pending, 4 sub-source mask.
- R2: A rising edge on a non-grouped, non-reserved bit of `irq_in` sets the matching primary pending bit. Holding the input high does not set the bit again once it has been cleared. Writing 1 to a bit at offset 0 clears it, and writing 0 leaves it unchanged.
- R3: When a set request and a write-one clear reach the same pending bit in the same cycle, the bit ends up set.
- R4: Primary positions 6 and 24 never become pending, whatever `irq_in` does and whatever the mask holds.
- R5: A rising edge on a bit of `sub_in` sets the matching sub-source pending bit. Writing 1 to that bit at offset 3 clears it, and writing 0 has no effect.
- R6: Sub-source groups are bits 0-2, 3-5 and 6-8 (receive, transmit, error of serial ports 0, 1 and 2) and bits 9-10 (bit 9 touch panel, bit 10 converter done). They feed primary positions 28, 23, 15 and 31. A grouped primary bit is set while any sub-source of its group is pending with a sub-mask bit of 0. A sub-mask bit of 1 blocks it. The raw `irq_in` bits at those four positions are ignored.
- R7: The in-service register (offset 2) holds at most one set bit: the lowest-numbered source that is pending and unmasked. It loads only while it is empty. Later sources, even lower-numbered ones, do not replace it. Writing 0 to it has no effect.
- R8: A primary mask bit of 1 keeps that source out of the in-service register but still lets its pending bit be recorded. A mask bit of 0 enables the source.
- R9: `irq_out` is high exactly when the in-service register is non-zero. Writing 1 to the set bit at offset 2 empties the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Asynchronous primary request pins |
| sub_in | input | 11 | Asynchronous sub-source request pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 1 | Interrupt request to the CPU |

## Verification
A synchronized rising edge and a software write-one clear can reach the same pending bit in one cycle. The bench provokes this by raising a pin exactly two clock edges before a clear write to that bit, so that the edge detector fires on the edge where the write takes effect. The bit must read set afterwards. A separate clear with no edge present must still work. The same race is provoked on a grouped source: a clear is written while its sub-source stays pending and unmasked, and the grouped bit must survive until the sub-source itself is cleared.

// File: rtl/cascade_intc_pkg.sv
package cascade_intc_pkg;
  localparam int NSRC = 32;
  localparam int NSUB = 11;
  localparam int NGRP = 4;

  localparam logic [2:0] OFS_SRCPND  = 3'd0;
  localparam logic [2:0] OFS_MASK    = 3'd1;
  localparam logic [2:0] OFS_INSVC   = 3'd2;
  localparam logic [2:0] OFS_SUBPND  = 3'd3;
  localparam logic [2:0] OFS_SUBMASK = 3'd4;

  // sub-source group layout and the primary slot each group feeds
  localparam int GRP_BASE  [NGRP] = '{0, 3, 6, 9};
  localparam int GRP_WIDTH [NGRP] = '{3, 3, 3, 2};
  localparam int GRP_SRC   [NGRP] = '{28, 23, 15, 31};

  localparam logic [NSRC-1:0] RSV_MASK = (NSRC'(1) << 6) | (NSRC'(1) << 24);

  function automatic logic [NSRC-1:0] grp_src_mask();
    logic [NSRC-1:0] m;
    m = '0;
    for (int g = 0; g < NGRP; g++) m[GRP_SRC[g]] = 1'b1;
    return m;
  endfunction

  // isolate the lowest set bit: v AND two's complement of v
  function automatic logic [NSRC-1:0] lowest_set(input logic [NSRC-1:0] v);
    return v & (~v + NSRC'(1));
  endfunction

  function automatic logic [NGRP-1:0] group_hits(input logic [NSUB-1:0] pnd,
                                                 input logic [NSUB-1:0] msk);
    logic [NSUB-1:0] live;
    logic [NGRP-1:0] h;
    live = pnd & ~msk;
    h = '0;
    for (int g = 0; g < NGRP; g++)
      for (int b = 0; b < 3; b++)
        if (b < GRP_WIDTH[g]) h[g] = h[g] | live[GRP_BASE[g] + b];
    return h;
  endfunction
endpackage

// File: rtl/cintc_sync_edge.sv
module cintc_sync_edge #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] rise
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= raw;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= stg[STAGES-1];
  end

  assign rise = stg[STAGES-1] & ~prev;
endmodule

// File: rtl/cintc_sub_layer.sv
module cintc_sub_layer
  import cascade_intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSUB-1:0] sub_rise,
  input  logic            wr_pnd,
  input  logic            wr_msk,
  input  logic [NSUB-1:0] wdata,
  output logic [NSUB-1:0] subpnd_q,
  output logic [NSUB-1:0] submsk_q,
  output logic [NGRP-1:0] grp_req
);
  logic [NSUB-1:0] clr_vec;

  assign clr_vec = wr_pnd ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      subpnd_q <= '0;
      submsk_q <= '1;
    end else begin
      subpnd_q <= (subpnd_q & ~clr_vec) | sub_rise;
      if (wr_msk) submsk_q <= wdata;
    end
  end

  assign grp_req = group_hits(subpnd_q, submsk_q);
endmodule

// File: rtl/cintc_primary.sv
module cintc_primary
  import cascade_intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pin_rise,
  input  logic [NGRP-1:0] grp_req,
  input  logic            wr_srcpnd,
  input  logic            wr_mask,
  input  logic            wr_insvc,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] set_vec,
  output logic [NSRC-1:0] srcpnd_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] insvc_q
);
  localparam logic [NSRC-1:0] GRP_MASK = grp_src_mask();

  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] candidate;

  always_comb begin
    set_vec = pin_rise & ~RSV_MASK & ~GRP_MASK;
    for (int g = 0; g < NGRP; g++) set_vec[GRP_SRC[g]] = grp_req[g];
  end

  assign clr_vec   = wr_srcpnd ? wdata : '0;
  assign candidate = srcpnd_q & ~mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcpnd_q <= '0;
      mask_q   <= '1;
      insvc_q  <= '0;
    end else begin
      srcpnd_q <= (srcpnd_q & ~clr_vec) | set_vec;
      if (wr_mask) mask_q <= wdata;
      if (insvc_q == '0)  insvc_q <= lowest_set(candidate);
      else if (wr_insvc)  insvc_q <= insvc_q & ~wdata;
    end
  end
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
  import cascade_intc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSUB-1:0] sub_in,
  input  logic            bus_we,
  input  logic [2:0]      bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_out
);
  logic [NSRC-1:0] pin_rise;
  logic [NSUB-1:0] sub_rise;
  logic [NGRP-1:0] grp_req;
  logic [NSRC-1:0] set_vec, srcpnd_q, mask_q, insvc_q;
  logic [NSUB-1:0] subpnd_q, submsk_q;
  logic            wr_srcpnd, wr_mask, wr_insvc, wr_subpnd, wr_submsk;

  assign wr_srcpnd = bus_we && (bus_addr == OFS_SRCPND);
  assign wr_mask   = bus_we && (bus_addr == OFS_MASK);
  assign wr_insvc  = bus_we && (bus_addr == OFS_INSVC);
  assign wr_subpnd = bus_we && (bus_addr == OFS_SUBPND);
  assign wr_submsk = bus_we && (bus_addr == OFS_SUBMASK);

  cintc_sync_edge #(.W(NSRC), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .rise(pin_rise));

  cintc_sync_edge #(.W(NSUB), .STAGES(SYNC_STAGES)) u_sub_sync (
    .clk(clk), .rst_n(rst_n), .raw(sub_in), .rise(sub_rise));

  cintc_sub_layer u_sub (
    .clk(clk), .rst_n(rst_n), .sub_rise(sub_rise),
    .wr_pnd(wr_subpnd), .wr_msk(wr_submsk), .wdata(bus_wdata[NSUB-1:0]),
    .subpnd_q(subpnd_q), .submsk_q(submsk_q), .grp_req(grp_req));

  cintc_primary u_pri (
    .clk(clk), .rst_n(rst_n), .pin_rise(pin_rise), .grp_req(grp_req),
    .wr_srcpnd(wr_srcpnd), .wr_mask(wr_mask), .wr_insvc(wr_insvc),
    .wdata(bus_wdata), .set_vec(set_vec), .srcpnd_q(srcpnd_q),
    .mask_q(mask_q), .insvc_q(insvc_q));

  always_comb begin
    unique case (bus_addr)
      OFS_SRCPND:  bus_rdata = srcpnd_q;
      OFS_MASK:    bus_rdata = mask_q;
      OFS_INSVC:   bus_rdata = insvc_q;
      OFS_SUBPND:  bus_rdata = {{(NSRC-NSUB){1'b0}}, subpnd_q};
      OFS_SUBMASK: bus_rdata = {{(NSRC-NSUB){1'b0}}, submsk_q};
      default:     bus_rdata = '0;
    endcase
  end

  assign irq_out = |insvc_q;
endmodule

// File: rtl/cascade_intc_chk.sv
module cascade_intc_chk
  import cascade_intc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] set_vec,
  input logic [NSRC-1:0] srcpnd_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] insvc_q,
  input logic            wr_insvc
);
  AST_INSVC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(insvc_q)); // R7

  AST_INSVC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_q != '0 && !wr_insvc) |=> $stable(insvc_q)); // R7

  AST_LOAD_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (insvc_q == '0) |=> ((insvc_q & $past(mask_q)) == '0)); // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((srcpnd_q & $past(set_vec)) == $past(set_vec))); // R3

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((srcpnd_q & RSV_MASK) == '0)); // R4
endmodule

bind cascade_intc cascade_intc_chk chk_i (
  .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .srcpnd_q(srcpnd_q),
  .mask_q(mask_q), .insvc_q(insvc_q), .wr_insvc(wr_insvc));

// File: tb/cascade_intc_tb_top.sv
`timescale 1ns/1ps
module cascade_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [10:0] sub_in = '0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cascade_intc dut_i (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .sub_in(sub_in),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic settle(); repeat (6) @(negedge clk); endtask

  task automatic pulse_pin(input int b);
    @(negedge clk); irq_in[b] = 1'b1;
    repeat (4) @(negedge clk); irq_in[b] = 1'b0;
    settle();
  endtask

  task automatic pulse_sub(input int b);
    @(negedge clk); sub_in[b] = 1'b1;
    repeat (4) @(negedge clk); sub_in[b] = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, d); check("R1", "srcpnd", d, 32'h0);
    rd(3'd1, d); check("R1", "mask", d, 32'hFFFF_FFFF);
    rd(3'd2, d); check("R1", "insvc", d, 32'h0);
    rd(3'd3, d); check("R1", "subpnd", d, 32'h0);
    rd(3'd4, d); check("R1", "submask", d, 32'h7FF);
    check("R1", "irq_out", {31'd0, irq_out}, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); irq_in[3] = 1'b1; settle();
    rd(3'd0, d); check("R2", "edge sets bit3", d, 32'h8);
    wr(3'd0, 32'h8); settle();
    rd(3'd0, d); check("R2", "held level does not reset bit3", d, 32'h0);
    irq_in[3] = 1'b0;
    pulse_pin(5);
    wr(3'd0, 32'h0); settle();
    rd(3'd0, d); check("R2", "write zero keeps bit5", d, 32'h20);
    wr(3'd0, 32'h20);
    rd(3'd0, d); check("R2", "write one clears bit5", d, 32'h0);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(3'd1, 32'h0);
    pulse_pin(6); pulse_pin(24); pulse_pin(28);
    rd(3'd0, d); check("R4", "reserved and raw grouped pins idle", d, 32'h0);
    check("R4", "no request", {31'd0, irq_out}, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    @(negedge clk); irq_in[3] = 1'b1; irq_in[10] = 1'b1;
    repeat (4) @(negedge clk); irq_in[3] = 1'b0; irq_in[10] = 1'b0;
    settle();
    rd(3'd0, d); check("R8", "masked sources recorded", d, 32'h408);
    rd(3'd2, d); check("R8", "masked sources not in service", d, 32'h0);
    wr(3'd1, ~32'h400); settle();
    rd(3'd2, d); check("R8", "only unmasked bit10 served", d, 32'h400);
    wr(3'd1, ~32'h408); settle();
    rd(3'd2, d); check("R7", "bit10 kept after lower unmask", d, 32'h400);
    wr(3'd2, 32'h0); settle();
    rd(3'd2, d); check("R7", "write zero keeps in-service", d, 32'h400);
    check("R9", "irq_out high", {31'd0, irq_out}, 32'h1);
    wr(3'd0, 32'h400); wr(3'd2, 32'h400); settle();
    rd(3'd2, d); check("R7", "lowest pending loads next", d, 32'h8);
    wr(3'd0, 32'h8); wr(3'd2, 32'h8); settle();
    rd(3'd2, d); check("R9", "in-service emptied", d, 32'h0);
    check("R9", "irq_out low", {31'd0, irq_out}, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_sub();
    logic [31:0] d;
    pulse_sub(4);
    rd(3'd3, d); check("R5", "sub edge sets bit4", d, 32'h10);
    rd(3'd0, d); check("R6", "sub-masked group idle", d, 32'h0);
    wr(3'd4, 32'h7FF & ~32'h10); settle();
    rd(3'd0, d); check("R6", "serial1 group at 23", d, 32'h0080_0000);
    wr(3'd0, 32'h0080_0000); settle();
    rd(3'd0, d); check("R3", "group stays while sub pending", d, 32'h0080_0000);
    wr(3'd3, 32'h0); settle();
    rd(3'd3, d); check("R5", "sub write zero no effect", d, 32'h10);
    wr(3'd3, 32'h10); wr(3'd0, 32'h0080_0000); settle();
    rd(3'd0, d); check("R6", "group clears after sub clear", d, 32'h0);
    pulse_sub(10);
    wr(3'd4, 32'h3FF); settle();
    rd(3'd0, d); check("R6", "converter group at 31", d, 32'h8000_0000);
    wr(3'd4, 32'h7FF); wr(3'd3, 32'h400); wr(3'd0, 32'h8000_0000); settle();
    rd(3'd3, d); check("R5", "sub cleared", d, 32'h0);
    rd(3'd0, d); check("R6", "converter group cleared", d, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    pulse_pin(12);
    @(negedge clk); irq_in[12] = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 32'h1000;
    @(negedge clk); bus_we = 1'b0;
    settle();
    rd(3'd0, d); check("R3", "edge wins over same-cycle clear", d, 32'h1000);
    irq_in[12] = 1'b0; settle();
    wr(3'd0, 32'h1000);
    rd(3'd0, d); check("R3", "plain clear works", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_edge();
    t_reserved();
    t_priority();
    t_sub();
    t_same_cycle();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL all-R watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule